// File: doc/BRIEF.md
# Auto-MDIX Link Resolution Sequencer

This block brings up a copper Ethernet port when it is not known whether the cable crosses the transmit and receive pairs. After a start pulse it drives a single crossover-select output, waits a fixed settling time, and reads the PHY's basic status register through a request/acknowledge register-read port. Each failed link check flips the select output, and another check follows, until link appears or the retry budget runs out. The serial management engine that actually performs the reads sits outside this block.

Once link is up, the block works out what was negotiated. It re-reads basic status. It reads a vendor status register and decodes a 3-bit speed/duplex code. When autonegotiation was in use, it also walks the expansion, advertisement and partner-ability registers to decide whether pause frames may be used. The outcome is held on done/fail outputs with link, speed, duplex and pause flags until the next start.

Top module: `mdix_link_seq`

## Requirements
- R1: After reset the select output is 0 (straight-through), done, fail and rd_req are 0. A start pulse is accepted only in the idle, done or fail state. It clears all result flags and forces the select output back to 0 before the first check.
- R2: Every link check is preceded by a wait of exactly WAIT_CYCLES clock cycles with rd_req low. It then reads register address 1 at PHY address PHY_ADDR.
- R3: Link is present when bit 2 of the returned register-1 word is 1. On a failed check that is not the last one, the select output inverts, so checks alternate 0,1,0,1... The select output changes only in the cycle after an acknowledge or a start.
- R4: After RETRIES failed checks the block raises fail and no further check is made. Link and pause are reported as 0. A link found on the final permitted check still ends in done.
- R5: After link, register 1 is read once more. Register 31 is read only if bit 5 of that word is 1, and its bits 4:2 give the code: 1 = 10 Mb/s half, 5 = 10 Mb/s full, 2 = 100 Mb/s half, 6 = 100 Mb/s full (res_speed100 = 1 for 100 Mb/s, res_full = 1 for full duplex).
- R6: Any other speed code, or a skipped register-31 read, leaves res_speed100 and res_full at 0.
- R7: Register 6 is read only when bits 5 and 3 of the second register-1 word are both 1. Register 4 is read only if bit 0 of register 6 is 1. Register 5 is read only if bit 10 of register 4 is 1. res_pause is 1 only if bit 10 of register 5 is 1.
- R8: Whenever the sequence ends with link present, done is 1 and res_link is 1, whatever the decode result. done and fail are never both 1.
- R9: rd_req, once raised, stays high with rd_reg and rd_phy unchanged until the cycle in which rd_ack is 1. rd_data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a bring-up sequence |
| rd_ack | input | 1 | One-cycle acknowledge of the pending register read |
| rd_data | input | 16 | Register contents, valid with rd_ack |
| xover | output | 1 | Crossover select: 0 straight-through, 1 crossed |
| rd_req | output | 1 | Register read request |
| rd_phy | output | 5 | PHY address of the request |
| rd_reg | output | 5 | Register address of the request |
| done | output | 1 | Sequence finished with link |
| fail | output | 1 | Retry budget exhausted without link |
| res_link | output | 1 | Link present |
| res_speed100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| res_full | output | 1 | 1 = full duplex |
| res_pause | output | 1 | Pause usable on both ends |

## Verification
The bench drives the block from a PHY model whose link appears only for a chosen select value and only from a chosen check onward. This exposes a sequencer that forgets to flip, flips one check late, or does not restart from straight-through on a second start. It covers link on the very last permitted check and a link that never appears. An off-by-one retry counter then either fails early or makes one check too many. The register reads made after link are counted per address, so a design that reads the pause registers without the gating bits, or reads the speed register when negotiation is incomplete, shows up as a wrong count or a stray pause flag. An unrecognised speed code must leave both speed flags clear.

// File: rtl/mdix_pkg.sv
package mdix_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LINK,
    ST_STAT,
    ST_SPEED,
    ST_EXPN,
    ST_ADV,
    ST_LPA,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  localparam logic [4:0] REG_BSR  = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_LPA  = 5'd5;
  localparam logic [4:0] REG_EXPN = 5'd6;
  localparam logic [4:0] REG_SPD  = 5'd31;

  localparam int BIT_LINK     = 2;
  localparam int BIT_AN_ABLE  = 3;
  localparam int BIT_AN_DONE  = 5;
  localparam int BIT_PART_AN  = 0;
  localparam int BIT_PAUSE    = 10;

endpackage

// File: rtl/mdix_wait_timer.sv
module mdix_wait_timer #(
  parameter int WAIT_CYCLES = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = '0;
    else if (run && !expired)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdix_retry_ctr.sv
module mdix_retry_ctr #(
  parameter int RETRIES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic incr,
  output logic last
);
  localparam int RW = (RETRIES > 1) ? $clog2(RETRIES) : 1;
  localparam logic [RW-1:0] FINAL = RW'(RETRIES - 1);

  logic [RW-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == FINAL);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (incr && !last)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdix_speed_decode.sv
module mdix_speed_decode (
  input  logic [2:0] code,
  output logic       is100,
  output logic       is_full
);
  always_comb begin
    is100   = 1'b0;
    is_full = 1'b0;
    case (code)
      3'd1: begin is100 = 1'b0; is_full = 1'b0; end
      3'd5: begin is100 = 1'b0; is_full = 1'b1; end
      3'd2: begin is100 = 1'b1; is_full = 1'b0; end
      3'd6: begin is100 = 1'b1; is_full = 1'b1; end
      default: begin is100 = 1'b0; is_full = 1'b0; end
    endcase
  end
endmodule

// File: rtl/mdix_link_seq.sv
module mdix_link_seq
  import mdix_pkg::*;
#(
  parameter int         WAIT_CYCLES = 400_000_000,
  parameter int         RETRIES     = 100,
  parameter logic [4:0] PHY_ADDR    = 5'd6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_ack,
  input  logic [15:0] rd_data,
  output logic        xover,
  output logic        rd_req,
  output logic [4:0]  rd_phy,
  output logic [4:0]  rd_reg,
  output logic        done,
  output logic        fail,
  output logic        res_link,
  output logic        res_speed100,
  output logic        res_full,
  output logic        res_pause
);

  seq_state_t st_q, st_d;
  logic xover_q, xover_d;
  logic an_q, an_d;
  logic link_q, link_d, spd_q, spd_d, full_q, full_d, pause_q, pause_d;
  logic tmr_load, tmr_exp, rc_clr, rc_inc, rc_last;
  logic dec_100, dec_full;
  logic unused_bits;

  assign unused_bits = ^{rd_data[15:11], rd_data[9:6], rd_data[1]};

  mdix_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .run(st_q == ST_WAIT), .expired(tmr_exp)
  );

  mdix_retry_ctr #(.RETRIES(RETRIES)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(rc_clr), .incr(rc_inc), .last(rc_last)
  );

  mdix_speed_decode u_dec (
    .code(rd_data[4:2]), .is100(dec_100), .is_full(dec_full)
  );

  // Read port driven from state
  always_comb begin
    rd_req = 1'b1;
    rd_reg = REG_BSR;
    case (st_q)
      ST_LINK, ST_STAT: rd_reg = REG_BSR;
      ST_SPEED:         rd_reg = REG_SPD;
      ST_EXPN:          rd_reg = REG_EXPN;
      ST_ADV:           rd_reg = REG_ADV;
      ST_LPA:           rd_reg = REG_LPA;
      default:          rd_req = 1'b0;
    endcase
  end

  assign rd_phy       = PHY_ADDR;
  assign xover        = xover_q;
  assign done         = (st_q == ST_DONE);
  assign fail         = (st_q == ST_FAIL);
  assign res_link     = link_q;
  assign res_speed100 = spd_q;
  assign res_full     = full_q;
  assign res_pause    = pause_q;

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    xover_d  = xover_q;
    an_d     = an_q;
    link_d   = link_q;
    spd_d    = spd_q;
    full_d   = full_q;
    pause_d  = pause_q;
    tmr_load = 1'b0;
    rc_clr   = 1'b0;
    rc_inc   = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          st_d     = ST_WAIT;
          xover_d  = 1'b0;
          an_d     = 1'b0;
          link_d   = 1'b0;
          spd_d    = 1'b0;
          full_d   = 1'b0;
          pause_d  = 1'b0;
          tmr_load = 1'b1;
          rc_clr   = 1'b1;
        end
      end
      ST_WAIT: if (tmr_exp) st_d = ST_LINK;
      ST_LINK: if (rd_ack) begin
        if (rd_data[BIT_LINK])
          st_d = ST_STAT;
        else if (rc_last)
          st_d = ST_FAIL;
        else begin
          xover_d  = ~xover_q;
          rc_inc   = 1'b1;
          tmr_load = 1'b1;
          st_d     = ST_WAIT;
        end
      end
      ST_STAT: if (rd_ack) begin
        an_d = rd_data[BIT_AN_ABLE];
        st_d = rd_data[BIT_AN_DONE] ? ST_SPEED : ST_DONE;
      end
      ST_SPEED: if (rd_ack) begin
        spd_d  = dec_100;
        full_d = dec_full;
        st_d   = an_q ? ST_EXPN : ST_DONE;
      end
      ST_EXPN: if (rd_ack) st_d = rd_data[BIT_PART_AN] ? ST_ADV : ST_DONE;
      ST_ADV:  if (rd_ack) st_d = rd_data[BIT_PAUSE] ? ST_LPA : ST_DONE;
      ST_LPA: if (rd_ack) begin
        pause_d = rd_data[BIT_PAUSE];
        st_d    = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_d == ST_DONE && st_q != ST_DONE)
      link_d = 1'b1;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      xover_q <= 1'b0;
      an_q    <= 1'b0;
      link_q  <= 1'b0;
      spd_q   <= 1'b0;
      full_q  <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      xover_q <= xover_d;
      an_q    <= an_d;
      link_q  <= link_d;
      spd_q   <= spd_d;
      full_q  <= full_d;
      pause_q <= pause_d;
    end
  end

endmodule

// File: rtl/mdix_link_seq_chk.sv
module mdix_link_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       rd_ack,
  input logic       xover,
  input logic       rd_req,
  input logic [4:0] rd_phy,
  input logic [4:0] rd_reg,
  input logic       done,
  input logic       fail,
  input logic       res_link,
  input logic       res_pause
);

  // R9: request held with a stable address until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_reg) && $stable(rd_phy)));

  // R3: select output changes only at a retry boundary or a start
  a_r3_xover_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xover) |-> ($past(rd_ack) || $past(start)));

  // R4: a failed sequence reports neither link nor pause
  a_r4_fail_nolink: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!res_link && !res_pause));

  // R8: completion always carries the link flag
  a_r8_done_link: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_link);

  // R8: done and fail are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R7: pause is only ever raised by the partner-ability read
  a_r7_pause_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_pause) |-> ($past(rd_ack) && ($past(rd_reg) == 5'd5)));

endmodule

bind mdix_link_seq mdix_link_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_ack(rd_ack),
  .xover(xover), .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg),
  .done(done), .fail(fail), .res_link(res_link), .res_pause(res_pause)
);

// File: tb/mdix_link_seq_tb_top.sv
`timescale 1ns/1ps
module mdix_link_seq_tb_top;

  localparam int         W   = 8;
  localparam int         R   = 6;
  localparam logic [4:0] PHY = 5'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_ack = 1'b0;
  logic [15:0] rd_data = 16'h0;
  logic        xover, rd_req, done, fail;
  logic        res_link, res_speed100, res_full, res_pause;
  logic [4:0]  rd_phy, rd_reg;

  always #2.5 clk = ~clk;

  mdix_link_seq #(.WAIT_CYCLES(W), .RETRIES(R), .PHY_ADDR(PHY)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_ack(rd_ack), .rd_data(rd_data),
    .xover(xover), .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg),
    .done(done), .fail(fail), .res_link(res_link), .res_speed100(res_speed100),
    .res_full(res_full), .res_pause(res_pause)
  );

  typedef struct {
    bit is_done; bit link; bit spd; bit full; bit pause;
    int nchk; int n31; int n6; int n4; int n5;
  } exp_t;

  exp_t sb_q[$];
  int total = 0, failed = 0;
  bit finished = 0;

  // PHY model configuration
  bit cfg_good, cfg_never, cfg_b5, cfg_b3, cfg_e0, cfg_a10, cfg_l10;
  int cfg_after;
  bit [2:0] cfg_code;
  int nchk, n31, n6, n4, n5, pend, idle_run;
  bit linked;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // PHY model: acknowledges each request two cycles after it appears
  initial begin
    pend = 0; idle_run = 0; linked = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 1'b0;
        pend = 0;
        idle_run = rd_req ? 0 : 1;
      end else if (rd_req) begin
        if (pend == 0 && rd_reg == 5'd1 && !linked && nchk > 0)
          chk(idle_run == W, "R2", "wait before retry", idle_run, W);
        idle_run = 0;
        pend++;
        if (pend == 2) begin
          chk(rd_phy == PHY, "R2", "phy address", rd_phy, PHY);
          rd_data = 16'h0;
          case (rd_reg)
            5'd1: begin
              if (!linked) begin
                nchk++;
                chk(xover == bit'((nchk - 1) % 2), "R3", "select alternation",
                    xover, (nchk - 1) % 2);
                if (!cfg_never && xover == cfg_good && nchk >= cfg_after) begin
                  linked = 1;
                  rd_data[2] = 1'b1;
                end
              end else begin
                rd_data[2] = 1'b1;
                rd_data[3] = cfg_b3;
                rd_data[5] = cfg_b5;
              end
            end
            5'd31: begin n31++; rd_data[4:2] = cfg_code; end
            5'd6:  begin n6++;  rd_data[0]  = cfg_e0;  end
            5'd4:  begin n4++;  rd_data[10] = cfg_a10; end
            5'd5:  begin n5++;  rd_data[10] = cfg_l10; end
            default: chk(1'b0, "R7", "unexpected register", rd_reg, 0);
          endcase
          rd_ack = 1'b1;
        end
      end else begin
        pend = 0;
        idle_run++;
      end
    end
  end

  // Monitor: pops an expected item when a sequence ends
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if ((done || fail) && !prev) begin
        exp_t e;
        if (sb_q.size() == 0) chk(1'b0, "R8", "unexpected completion", 1, 0);
        else begin
          e = sb_q.pop_front();
          chk(done == e.is_done, "R8", "done", done, e.is_done);
          chk(fail == !e.is_done, "R4", "fail", fail, !e.is_done);
          chk(res_link == e.link, "R8", "link flag", res_link, e.link);
          chk(nchk == e.nchk, "R4", "link checks", nchk, e.nchk);
          chk(res_speed100 == e.spd, "R5", "speed", res_speed100, e.spd);
          chk(res_full == e.full, "R6", "duplex", res_full, e.full);
          chk(n31 == e.n31, "R5", "speed reads", n31, e.n31);
          chk(n6 == e.n6, "R7", "expansion reads", n6, e.n6);
          chk(n4 == e.n4, "R7", "advert reads", n4, e.n4);
          chk(n5 == e.n5, "R7", "partner reads", n5, e.n5);
          chk(res_pause == e.pause, "R7", "pause", res_pause, e.pause);
        end
      end
      prev = done || fail;
    end
  end

  task automatic run_case(input bit good, input int after, input bit never,
                          input bit b5, input bit b3, input bit [2:0] code,
                          input bit e0, input bit a10, input bit l10);
    exp_t e;
    int guard;
    cfg_good = good; cfg_after = after; cfg_never = never;
    cfg_b5 = b5; cfg_b3 = b3; cfg_code = code;
    cfg_e0 = e0; cfg_a10 = a10; cfg_l10 = l10;
    nchk = 0; n31 = 0; n6 = 0; n4 = 0; n5 = 0; linked = 0;
    // expected outcome from the requirements
    e.is_done = 0; e.nchk = R;
    if (!never)
      for (int i = 1; i <= R; i++)
        if (((i - 1) % 2) == int'(good) && i >= after) begin
          e.is_done = 1; e.nchk = i; break;
        end
    e.link = e.is_done;
    e.n31 = (e.is_done && b5) ? 1 : 0;
    e.spd = 0; e.full = 0;
    if (e.n31 == 1)
      case (code)
        3'd1: begin e.spd = 0; e.full = 0; end
        3'd5: begin e.spd = 0; e.full = 1; end
        3'd2: begin e.spd = 1; e.full = 0; end
        3'd6: begin e.spd = 1; e.full = 1; end
        default: begin e.spd = 0; e.full = 0; end
      endcase
    e.n6 = (e.n31 == 1 && b3) ? 1 : 0;
    e.n4 = (e.n6 == 1 && e0) ? 1 : 0;
    e.n5 = (e.n4 == 1 && a10) ? 1 : 0;
    e.pause = (e.n5 == 1 && l10);
    sb_q.push_back(e);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !fail, "R1", "result cleared by start", done | fail, 0);
    guard = 0;
    while (!(done || fail) && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(xover == 1'b0, "R1", "reset select", xover, 0);
    chk(!done && !fail, "R1", "reset done/fail", done | fail, 0);
    chk(rd_req == 1'b0, "R1", "reset request", rd_req, 0);
    rst_n = 1'b1;
    repeat (W + 4) @(negedge clk);
    chk(rd_req == 1'b0 && xover == 1'b0, "R1", "idle without start", rd_req | xover, 0);
    // link on first check, 100 full, pause on both ends
    run_case(0, 1, 0, 1, 1, 3'd6, 1, 1, 1);
    // crossed cable, 10 full, partner cannot negotiate
    run_case(1, 1, 0, 1, 1, 3'd5, 0, 1, 1);
    // third check, restarts from straight-through; 100 half, no pause advert
    run_case(0, 3, 0, 1, 1, 3'd2, 1, 0, 1);
    // negotiation incomplete: no speed read, link still reported
    run_case(0, 1, 0, 0, 1, 3'd6, 1, 1, 1);
    // unknown speed code, partner lacks pause
    run_case(1, 2, 0, 1, 1, 3'd7, 1, 1, 0);
    // no negotiation ability: pause chain skipped
    run_case(0, 1, 0, 1, 0, 3'd1, 1, 1, 1);
    // link only on the final permitted check
    run_case(1, R, 0, 1, 1, 3'd6, 1, 1, 1);
    // never any link: fail after the budget
    run_case(0, 1, 1, 1, 1, 3'd6, 1, 1, 1);
    // recovery after fail
    run_case(0, 1, 0, 1, 0, 3'd5, 0, 0, 0);
    chk(sb_q.size() == 0, "R8", "all sequences completed", sb_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; failed++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule